// File: doc/BRIEF.md
# Protected Clock Control Register

This block is the byte-wide control register through which software steers a microcontroller clock generator. It holds four control fields: a PLL enable, a spread-spectrum generator enable, a dithering-mode enable and a peripheral clock source select. Each field drives the clock tree directly. Of the eight bits, the remaining four always read as zero.

Every write to the control byte is guarded. Software must first write a fixed key to a separate command address. The very next bus access must then be the control write. Any break in that handshake leaves the register untouched and raises a sticky error flag, which software reads and clears at a third address.

The two enable bits can only be set by software. Hardware clears them, and the peripheral clock select with them, while the chip reports a standby mode. Hardware also protects the enables and the dithering field in two ways:

- An enable cannot be set while the main oscillator is reported unstable.
- The dithering field is frozen while the spread-spectrum generator runs.

Top module: `clkgen_ctrl_reg`

## Requirements
- R1: After reset the control byte reads 0x00, all four field outputs are 0 and the error flag is 0.
- R2: A read of the control address (0) returns bit 7 = PLL enable, bit 6 = spread-spectrum enable, bit 5 = dithering enable, bit 3 = peripheral clock select. Bits 4, 2, 1 and 0 read 0 even after a write of 1 to them. The key address (1) reads 0x00, and the error address (2) returns the flag in bit 0.
- R3: An accepted control write with 1 in bit 7 or bit 6 sets that enable. A 0 in those bits leaves the enable as it was.
- R4: While the standby input is high, the PLL enable, the spread-spectrum enable and the peripheral clock select are 0 from the next clock edge. This wins over an accepted write in the same cycle. The dithering enable is not affected by standby.
- R5: An accepted write does not change the dithering enable (bit 5) while the spread-spectrum enable is 1. The other fields of that write are still applied.
- R6: While the oscillator-stable input is low, a write of 1 to bit 7 or bit 6 does not set that enable.
- R7: A control write that does not directly follow a key write changes nothing and sets the error flag.
- R8: Once the key 0xA5 has been written to address 1, the next bus access consumes the unlock. If that access is anything other than a control write, the unlock is cancelled and the error flag is set.
- R9: A write of any value other than 0xA5 to the key address does not unlock and sets the error flag.
- R10: A write of 1 to bit 0 at the error address clears the flag when no unlock is pending. If an error condition occurs in the same cycle, the flag stays set.
- R11: The four field outputs always equal the matching bits of the control byte read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_vld_i | input | 1 | Bus access valid this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address: 0 control, 1 key, 2 error |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i, combinational |
| stby_i | input | 1 | Chip is in a standby mode |
| osc_ok_i | input | 1 | Main oscillator has settled |
| pll_en_o | output | 1 | PLL enable |
| sscg_en_o | output | 1 | Spread-spectrum generator enable |
| dith_en_o | output | 1 | Dithering mode enable |
| pclk_pll_o | output | 1 | Peripheral clocks from PLL x4 (1) or main oscillator (0) |
| prot_err_o | output | 1 | Sticky protection error flag |

## Verification
The bench drives the main function with several access patterns, each chosen to tell one fault apart:

- A clean key-then-write pair shows that the unlock and the set path work.
- A write of all ones, followed by a write of all zeros, separates set-only enables from plain storage bits, and shows that the zero bits stay zero.
- A key followed by a read, and a wrong key followed by a write, show that the unlock is consumed by any access and not only by a write.
- Standby raised in the same cycle as an accepted write shows which of the two wins.
- Writes made with the oscillator low, and with the spread-spectrum generator running, expose each hardware guard in isolation.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned POS_PLL  = 7;
   localparam int unsigned POS_SSCG = 6;
   localparam int unsigned POS_DITH = 5;
   localparam int unsigned POS_PCLK = 3;

   typedef struct packed {
      logic pll;
      logic sscg;
      logic dith;
      logic pclk;
   } ctl_fields_t;

   function automatic logic [BYTE_W-1:0] pack_ctl(ctl_fields_t f);
      logic [BYTE_W-1:0] b;
      b = '0;
      b[POS_PLL]  = f.pll;
      b[POS_SSCG] = f.sscg;
      b[POS_DITH] = f.dith;
      b[POS_PCLK] = f.pclk;
      return b;
   endfunction
endpackage

// File: rtl/clkctl_unlock.sv
module clkctl_unlock #(
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned DATA_W    = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 0,
   parameter logic [ADDR_W-1:0] KEY_ADDR  = 1,
   parameter logic [ADDR_W-1:0] ERR_ADDR  = 2,
   parameter logic [DATA_W-1:0] KEY_VALUE = 8'hA5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              vld_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              wr_ok_o,
   output logic              err_o
);
   logic armed_q, err_q;
   logic ctrl_wr, key_wr, key_good, err_clr, err_set;

   assign ctrl_wr  = vld_i && wr_i && (addr_i == CTRL_ADDR);
   assign key_wr   = vld_i && wr_i && (addr_i == KEY_ADDR);
   assign key_good = key_wr && (wdata_i == KEY_VALUE);
   assign err_clr  = vld_i && wr_i && (addr_i == ERR_ADDR) && wdata_i[0] && !armed_q;
   assign err_set  = (vld_i && armed_q && !ctrl_wr)
                  || (!armed_q && ctrl_wr)
                  || (!armed_q && key_wr && !key_good);
   assign wr_ok_o  = armed_q && ctrl_wr;
   assign err_o    = err_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         if (vld_i) armed_q <= !armed_q && key_good;
         if (err_set)      err_q <= 1'b1;
         else if (err_clr) err_q <= 1'b0;
      end
   end

   // R7: unprotected control write flags an error
   a_r7_unkeyed_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_i && wr_i && addr_i == CTRL_ADDR && !armed_q) |=> err_q);
   // R8: a pending unlock never survives a bus access
   a_r8_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_i && armed_q) |=> !armed_q);
   // R9: a wrong key never arms
   a_r9_bad_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_i && wr_i && addr_i == KEY_ADDR && wdata_i != KEY_VALUE) |=> (!armed_q && err_q));
endmodule

// File: rtl/clkctl_fields.sv
module clkctl_fields
   import clkctl_pkg::*;
#(
   parameter bit GATE_ON_OSC = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_ok_i,
   input  logic [BYTE_W-1:0] wdata_i,
   input  logic              stby_i,
   input  logic              osc_ok_i,
   output ctl_fields_t       q_o
);
   ctl_fields_t q, d;
   logic set_allow;

   generate
      if (GATE_ON_OSC) begin : g_gate
         assign set_allow = osc_ok_i;
      end else begin : g_nogate
         assign set_allow = 1'b1;
      end
   endgenerate

   always_comb begin
      d = q;
      if (wr_ok_i) begin
         if (wdata_i[POS_PLL]  && set_allow) d.pll  = 1'b1;
         if (wdata_i[POS_SSCG] && set_allow) d.sscg = 1'b1;
         if (!q.sscg) d.dith = wdata_i[POS_DITH];
         d.pclk = wdata_i[POS_PCLK];
      end
      if (stby_i) begin
         d.pll  = 1'b0;
         d.sscg = 1'b0;
         d.pclk = 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d;
   end

   assign q_o = q;

   // R3: software never clears an enable
   a_r3_pll_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q.pll && !stby_i) |=> q.pll);
   a_r3_sscg_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q.sscg && !stby_i) |=> q.sscg);
   // R4: standby clears the affected fields
   a_r4_stby_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stby_i |=> (!q.pll && !q.sscg && !q.pclk));
   // R5: dithering frozen while spread spectrum runs
   a_r5_dith_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q.sscg |=> $stable(q.dith));
   // R6: no enable set with unstable oscillator
   a_r6_osc_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!osc_ok_i && !q.pll) |=> !q.pll);
endmodule

// File: rtl/clkgen_ctrl_reg.sv
module clkgen_ctrl_reg
   import clkctl_pkg::*;
#(
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned DATA_W    = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 0,
   parameter logic [ADDR_W-1:0] KEY_ADDR  = 1,
   parameter logic [ADDR_W-1:0] ERR_ADDR  = 2,
   parameter logic [DATA_W-1:0] KEY_VALUE = 8'hA5,
   parameter bit GATE_ON_OSC = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_vld_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic              stby_i,
   input  logic              osc_ok_i,
   output logic              pll_en_o,
   output logic              sscg_en_o,
   output logic              dith_en_o,
   output logic              pclk_pll_o,
   output logic              prot_err_o
);
   localparam int unsigned NUM_ADDR = 3;

   generate
      if (DATA_W != BYTE_W) begin : g_bad_width
         $error("clkgen_ctrl_reg: DATA_W must equal BYTE_W");
      end
      if ((1 << ADDR_W) < NUM_ADDR) begin : g_bad_addr_w
         $error("clkgen_ctrl_reg: ADDR_W too small");
      end
      if (CTRL_ADDR == KEY_ADDR || CTRL_ADDR == ERR_ADDR || KEY_ADDR == ERR_ADDR) begin : g_bad_map
         $error("clkgen_ctrl_reg: addresses must differ");
      end
      if (KEY_VALUE == '0) begin : g_bad_key
         $error("clkgen_ctrl_reg: key must be nonzero");
      end
   endgenerate

   logic        wr_ok, err;
   ctl_fields_t flds;
   logic [DATA_W-1:0] ctl_byte;

   clkctl_unlock #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
      .KEY_ADDR(KEY_ADDR), .ERR_ADDR(ERR_ADDR), .KEY_VALUE(KEY_VALUE)
   ) u_unlock (
      .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(bus_vld_i), .wr_i(bus_wr_i),
      .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .wr_ok_o(wr_ok), .err_o(err)
   );

   clkctl_fields #(.GATE_ON_OSC(GATE_ON_OSC)) u_fields (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_ok_i(wr_ok), .wdata_i(bus_wdata_i),
      .stby_i(stby_i), .osc_ok_i(osc_ok_i), .q_o(flds)
   );

   assign ctl_byte = pack_ctl(flds);

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i == CTRL_ADDR)     bus_rdata_o = ctl_byte;
      else if (bus_addr_i == ERR_ADDR) bus_rdata_o[0] = err;
   end

   assign pll_en_o   = flds.pll;
   assign sscg_en_o  = flds.sscg;
   assign dith_en_o  = flds.dith;
   assign pclk_pll_o = flds.pclk;
   assign prot_err_o = err;

   // R2: reserved bits of the control byte read zero
   always_comb begin
      if (rst_ni && bus_addr_i == CTRL_ADDR)
         a_r2_zero_bits: assert (bus_rdata_o[4] == 1'b0 && bus_rdata_o[2:0] == 3'b000);
   end
   // R11: field outputs track the readable byte
   a_r11_outputs_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_addr_i == CTRL_ADDR) |-> (bus_rdata_o[7:5] == {pll_en_o, sscg_en_o, dith_en_o}
                                     && bus_rdata_o[3] == pclk_pll_o));
endmodule

// File: tb/clkgen_ctrl_reg_bench.sv
`timescale 1ns/1ps
module clkgen_ctrl_reg_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       vld = 1'b0, wr = 1'b0, stby = 1'b0, osc = 1'b1;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       pll, sscg, dith, pclk, perr;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   // reference model state
   bit m_pll, m_sscg, m_dith, m_pclk, m_err, m_arm;

   always #2 clk = ~clk;

   clkgen_ctrl_reg u_clkgen_ctrl_reg (
      .clk_i(clk), .rst_ni(rst_n), .bus_vld_i(vld), .bus_wr_i(wr),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .stby_i(stby), .osc_ok_i(osc), .pll_en_o(pll), .sscg_en_o(sscg),
      .dith_en_o(dith), .pclk_pll_o(pclk), .prot_err_o(perr)
   );

   function automatic logic [7:0] m_read(input logic [1:0] a);
      if (a == 2'd0) return {m_pll, m_sscg, m_dith, 1'b0, m_pclk, 3'b000};
      if (a == 2'd2) return {7'd0, m_err};
      return 8'h00;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // reference model update for one clock edge
   task automatic model_edge();
      bit cw, kw, kg, ok;
      cw = vld && wr && addr == 2'd0;
      kw = vld && wr && addr == 2'd1;
      kg = kw && wdata == 8'hA5;
      ok = m_arm && cw;
      if (ok) begin
         if (!m_sscg) m_dith = wdata[5];
         if (wdata[7] && osc) m_pll = 1;
         if (wdata[6] && osc) m_sscg = 1;
         m_pclk = wdata[3];
      end
      if (stby) begin m_pll = 0; m_sscg = 0; m_pclk = 0; end
      if ((vld && m_arm && !cw) || (!m_arm && cw) || (!m_arm && kw && !kg)) m_err = 1;
      else if (vld && wr && addr == 2'd2 && wdata[0] && !m_arm) m_err = 0;
      if (vld) m_arm = !m_arm && kg;
   endtask

   task automatic step(input string tag, input bit v, input bit w, input logic [1:0] a,
                       input logic [7:0] d, input bit s, input bit o);
      vld = v; wr = w; addr = a; wdata = d; stby = s; osc = o;
      #1;
      chk({tag, " rdata"}, rdata, m_read(a));
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk({tag, " outputs"}, {pll, sscg, dith, pclk, perr},
          {m_pll, m_sscg, m_dith, m_pclk, m_err});
   endtask

   task automatic idle(input string tag);
      step(tag, 0, 0, 2'd0, 8'h00, 0, 1);
   endtask

   task automatic pwrite(input string tag, input logic [7:0] d, input bit s, input bit o);
      step(tag, 1, 1, 2'd1, 8'hA5, 0, 1);
      step(tag, 1, 1, 2'd0, d, s, o);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1 reset", {rdata, pll, sscg, dith, pclk, perr}, 13'h0);
      idle("R1");
      // R2 / R3 / R11: set all, zero bits stay 0
      pwrite("R2 R3 set", 8'hFF, 0, 1);
      chk("R2 byte", rdata, 8'hE8);
      // R5: dither frozen while sscg on, pclk applied
      pwrite("R5 frozen", 8'h00, 0, 1);
      chk("R5 dith kept", dith, 1'b1);
      // R3: writing zeros leaves enables
      chk("R3 sticky", {pll, sscg}, 2'b11);
      pwrite("R3 write8", 8'h08, 0, 1);
      // R4: standby wins over same-cycle write
      pwrite("R4 stby", 8'hC8, 1, 1);
      chk("R4 cleared", {pll, sscg, pclk, dith}, 4'b0001);
      idle("R4 release");
      // R5: dither writable once sscg off
      pwrite("R5 free", 8'h00, 0, 1);
      chk("R5 dith cleared", dith, 1'b0);
      // R6: oscillator gate
      pwrite("R6 gated", 8'hC0, 0, 0);
      chk("R6 no set", {pll, sscg}, 2'b00);
      pwrite("R6 ok", 8'h80, 0, 1);
      // R7: unkeyed write
      step("R7 unkeyed", 1, 1, 2'd0, 8'h48, 0, 1);
      chk("R7 err", perr, 1'b1);
      step("R2 R10 read err", 0, 0, 2'd2, 8'h00, 0, 1);
      step("R10 clear", 1, 1, 2'd2, 8'h01, 0, 1);
      chk("R10 cleared", perr, 1'b0);
      // R8: intervening read cancels unlock
      step("R8 key", 1, 1, 2'd1, 8'hA5, 0, 1);
      step("R8 read", 1, 0, 2'd0, 8'h00, 0, 1);
      step("R8 late write", 1, 1, 2'd0, 8'h48, 0, 1);
      step("R10 clear2", 1, 1, 2'd2, 8'h01, 0, 1);
      // R9: wrong key
      step("R9 badkey", 1, 1, 2'd1, 8'h5A, 0, 1);
      step("R9 write", 1, 1, 2'd0, 8'h48, 0, 1);
      // R10: set wins over clear when unlock pending
      step("R10 clr0", 1, 1, 2'd2, 8'h01, 0, 1);
      step("R10 key", 1, 1, 2'd1, 8'hA5, 0, 1);
      step("R10 setwins", 1, 1, 2'd2, 8'h01, 0, 1);
      chk("R10 still set", perr, 1'b1);
      step("R2 keyread", 0, 0, 2'd1, 8'h00, 0, 1);
      // R4: standby alone
      step("R4 stby2", 0, 0, 2'd0, 8'h00, 1, 1);
      idle("R11 final");
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule